// File: doc/BRIEF.md
# Nibble Echo Byte Link Endpoint

This block is one end of a point-to-point byte link between two machines. Each direction of the link has five wires: four data bits and one phase bit. A byte crosses the link as two nibbles, low nibble first. The receiving end confirms each nibble by driving the same four bits back on its own wires and moving its own phase bit. The far side sees each phase bit inverted, and reads it as a busy status bit. The endpoint has a byte send port with valid/ready and a byte receive port with a one-cycle valid. It owns its five outgoing wires and samples the five incoming ones. The same instance can act as sender or as echoing receiver, one role at a time.

Every incoming wire passes through a synchronizer before any logic uses it. On each outgoing nibble the block drives the data bits one cycle before it moves the phase bit, so the far end always samples settled data. The sender checks each echoed nibble against what it sent and flags a mismatch. Both roles abandon a transfer when no answer arrives within a programmable number of cycles.

Top module: `nibble_link`

## Requirements
- R1: After reset, `link_out` is phase 1 with data 0 (5'h10), `tx_ready` is 1, and `rx_valid`, `tx_err`, `tx_timeout` and `rx_byte` are 0.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. After that edge `link_out[3:0]` carries bits 3:0 of the byte and `link_out[4]` stays 1. One edge later `link_out[4]` goes to 0.
- R3: A change on `link_in` takes effect at the third clock edge after it is applied, because of a two-flop synchronizer.
- R4: While the sender waits after its low nibble, `link_in[4]` = 1 is the echo. At that edge the sender drives bits 7:4 of the byte with the phase still 0. It sets the phase to 1 one edge later.
- R5: While the sender waits after its high nibble, `link_in[4]` = 0 is the echo. At that edge the sender goes idle and `tx_ready` returns to 1. For a byte 0x9A, 0xA goes out first and 0x9 second.
- R6: The sender compares the echoed data `link_in[3:0]` with the nibble it sent. A mismatch gives a one-cycle `tx_err` pulse at the edge that takes the echo, and the transfer still goes on.
- R7: The sender enters a wait on the edge where its phase bit changes. If no echo comes in the next `ack_limit`+1 edges, the last of those edges gives a one-cycle `tx_timeout` pulse and sets the phase to 1. The sender then goes idle.
- R8: An idle receiver starts on a 0-to-1 change of the synchronized `link_in[4]`. At that edge it copies `link_in[3:0]` onto `link_out[3:0]` and drops `tx_ready`. It drives phase 0 one edge later.
- R9: While the receiver waits, a synchronized `link_in[4]` of 0 marks the high nibble. At that edge the receiver echoes it on `link_out[3:0]`. One edge later it sets the phase to 1 and gives a one-cycle `rx_valid` with `rx_byte` = {high, low}.
- R10: A receiver that waits `ack_limit`+1 edges for the high nibble with no result returns the phase to 1 and goes idle, with no `rx_valid`.
- R11: A steady `link_in[4]` of 1 left over from a timed-out send never starts a receive. The block never acts as sender and receiver at once.
- R12: `tx_valid` while `tx_ready` is 0 is ignored: `link_out` does not change and no byte is sent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_limit | input | CNT_W | Extra cycles allowed for an echo or a high nibble |
| tx_byte | input | 2*NIB_W | Byte to send |
| tx_valid | input | 1 | Send request |
| tx_ready | output | 1 | Send port can take a byte |
| rx_byte | output | 2*NIB_W | Last byte received, {high, low} |
| rx_valid | output | 1 | One-cycle pulse: rx_byte is new |
| tx_err | output | 1 | One-cycle pulse: echoed nibble differed |
| tx_timeout | output | 1 | One-cycle pulse: send abandoned |
| link_out | output | NIB_W+1 | Outgoing wires: [NIB_W] phase, [NIB_W-1:0] data |
| link_in | input | NIB_W+1 | Incoming wires: [NIB_W] busy (far phase inverted), [NIB_W-1:0] data |

## Verification
The bench builds the block with four-bit nibbles, two synchronizer stages and a six-bit limit counter. The bench plays the far endpoint itself, so it controls the exact cycle of each echo, a wrong echo nibble, or no echo at all. It runs with `ack_limit` at 5 for complete transfers and at 3 for the timeout cases. This makes the limit boundary, expiry in either wait state and a stuck busy level short enough to check on every cycle.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LO_SET,
    TX_LO_WAIT,
    TX_HI_SET,
    TX_HI_WAIT
  } tx_st_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_LO_SET,
    RX_HI_WAIT,
    RX_HI_SET
  } rx_st_e;

  typedef enum logic {
    OWN_TX,
    OWN_RX
  } owner_e;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/link_wait_timer.sv
module link_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != limit) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);
endmodule

// File: rtl/link_tx.sv
module link_tx
  import link_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2*N-1:0] tx_byte,
  input  logic          tx_valid,
  input  logic          rx_idle,
  input  logic          rx_start,
  input  logic [N-1:0]  echo,
  input  logic          busy,
  input  logic [CW-1:0] limit,
  output logic          tx_ready,
  output logic          tx_idle,
  output logic          accept,
  output logic [N:0]    drv,
  output logic          tx_err,
  output logic          tx_timeout
);
  tx_st_e         st;
  logic [2*N-1:0] byte_q;
  logic [N-1:0]   data_q;
  logic           ph_q, err_q, to_q;
  logic           expired, waiting;

  assign waiting  = (st == TX_LO_WAIT) || (st == TX_HI_WAIT);
  assign tx_idle  = (st == TX_IDLE);
  assign tx_ready = tx_idle && rx_idle && !rx_start;
  assign accept   = tx_valid && tx_ready;

  link_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(waiting), .limit(limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      byte_q <= '0;
      data_q <= '0;
      ph_q   <= 1'b1;
      err_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      to_q  <= 1'b0;
      case (st)
        TX_IDLE: if (accept) begin
          byte_q <= tx_byte;
          data_q <= tx_byte[N-1:0];
          st     <= TX_LO_SET;
        end
        TX_LO_SET: begin
          ph_q <= 1'b0;
          st   <= TX_LO_WAIT;
        end
        TX_LO_WAIT: begin
          if (busy) begin
            err_q  <= (echo != byte_q[N-1:0]);
            data_q <= byte_q[2*N-1:N];
            st     <= TX_HI_SET;
          end else if (expired) begin
            to_q <= 1'b1;
            ph_q <= 1'b1;
            st   <= TX_IDLE;
          end
        end
        TX_HI_SET: begin
          ph_q <= 1'b1;
          st   <= TX_HI_WAIT;
        end
        TX_HI_WAIT: begin
          if (!busy) begin
            err_q <= (echo != byte_q[2*N-1:N]);
            st    <= TX_IDLE;
          end else if (expired) begin
            to_q <= 1'b1;
            st   <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign drv        = {ph_q, data_q};
  assign tx_err     = err_q;
  assign tx_timeout = to_q;

  // R2
  tx_lo_first_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (drv[N] && drv[N-1:0] == $past(tx_byte[N-1:0])));

  // R5
  tx_phase_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drv[N]) |-> (drv[N-1:0] == byte_q[N-1:0]));

  // R7
  tx_to_phase_chk: assert property (@(posedge clk) disable iff (rst)
    tx_timeout |-> (drv[N] && tx_idle));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !tx_ready) |=> $stable(byte_q));
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_idle,
  input  logic [N-1:0]   echo,
  input  logic           busy,
  input  logic [CW-1:0]  limit,
  output logic           rx_idle,
  output logic           rx_start,
  output logic [N:0]     drv,
  output logic [2*N-1:0] rx_byte,
  output logic           rx_valid
);
  rx_st_e         st;
  logic           busy_q, ph_q, rv_q, expired, waiting;
  logic [N-1:0]   lo_q, data_q;
  logic [2*N-1:0] byte_q;

  assign rx_idle  = (st == RX_IDLE);
  assign rx_start = rx_idle && tx_idle && busy && !busy_q;
  assign waiting  = (st == RX_HI_WAIT);

  link_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(waiting), .limit(limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      busy_q <= 1'b0;
      lo_q   <= '0;
      data_q <= '0;
      ph_q   <= 1'b1;
      byte_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q   <= 1'b0;
      busy_q <= busy;
      case (st)
        RX_IDLE: if (rx_start) begin
          lo_q   <= echo;
          data_q <= echo;
          st     <= RX_LO_SET;
        end
        RX_LO_SET: begin
          ph_q <= 1'b0;
          st   <= RX_HI_WAIT;
        end
        RX_HI_WAIT: begin
          if (!busy) begin
            data_q <= echo;
            st     <= RX_HI_SET;
          end else if (expired) begin
            ph_q <= 1'b1;
            st   <= RX_IDLE;
          end
        end
        RX_HI_SET: begin
          ph_q   <= 1'b1;
          rv_q   <= 1'b1;
          byte_q <= {data_q, lo_q};
          st     <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign drv      = {ph_q, data_q};
  assign rx_byte  = byte_q;
  assign rx_valid = rv_q;

  // R8
  rx_echo_lo_chk: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> (drv[N] && drv[N-1:0] == $past(echo)));

  // R9
  rx_valid_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (drv[N] && rx_byte[2*N-1:N] == drv[N-1:0]));

  // R9
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/nibble_link.sv
module nibble_link
  import link_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     ack_limit,
  input  logic [2*NIB_W-1:0]   tx_byte,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [2*NIB_W-1:0]   rx_byte,
  output logic                 rx_valid,
  output logic                 tx_err,
  output logic                 tx_timeout,
  output logic [NIB_W:0]       link_out,
  input  logic [NIB_W:0]       link_in
);
  localparam int LW = NIB_W + 1;

  logic [LW-1:0] in_s, tx_drv, rx_drv;
  logic          tx_idle, rx_idle, rx_start, accept;
  owner_e        owner;

  link_sync #(.W(LW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(link_in), .q(in_s)
  );

  link_tx #(.N(NIB_W), .CW(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .rx_idle(rx_idle), .rx_start(rx_start),
    .echo(in_s[NIB_W-1:0]), .busy(in_s[NIB_W]), .limit(ack_limit),
    .tx_ready(tx_ready), .tx_idle(tx_idle), .accept(accept), .drv(tx_drv),
    .tx_err(tx_err), .tx_timeout(tx_timeout)
  );

  link_rx #(.N(NIB_W), .CW(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .tx_idle(tx_idle),
    .echo(in_s[NIB_W-1:0]), .busy(in_s[NIB_W]), .limit(ack_limit),
    .rx_idle(rx_idle), .rx_start(rx_start), .drv(rx_drv),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)           owner <= OWN_TX;
    else if (accept)   owner <= OWN_TX;
    else if (rx_start) owner <= OWN_RX;
  end

  assign link_out = (owner == OWN_TX) ? tx_drv : rx_drv;

  // R11
  role_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!tx_idle && !rx_idle));

  // R11
  rx_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_idle |-> !tx_ready);
endmodule

// File: tb/nibble_link_tb.sv
`timescale 1ns/1ps
module nibble_link_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] ack_limit;
  logic [7:0] tx_byte;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       tx_err;
  logic       tx_timeout;
  logic [4:0] link_out;
  logic [4:0] link_in;

  logic [4:0] e_out;
  logic       e_rdy, e_rv, e_err, e_to;
  logic [7:0] e_rb;
  int         compared = 0;
  int         mismatched = 0;
  int         lim;
  bit         done = 0;
  string      cur_req;

  always #4 clk = ~clk;

  nibble_link #(.NIB_W(4), .SYNC_STAGES(2), .CNT_W(6)) u_dut (
    .clk(clk), .rst(rst), .ack_limit(ack_limit),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_err(tx_err), .tx_timeout(tx_timeout),
    .link_out(link_out), .link_in(link_in)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    chk("link_out", link_out, e_out);
    chk("tx_ready", tx_ready, e_rdy);
    chk("rx_valid", rx_valid, e_rv);
    chk("rx_byte", rx_byte, e_rb);
    chk("tx_err", tx_err, e_err);
    chk("tx_timeout", tx_timeout, e_to);
  endtask

  task automatic set_lim(input int v);
    lim = v;
    ack_limit = v[5:0];
  endtask

  // mode 0: full transfer, 1: no echo of low nibble, 2: no echo of high nibble
  task automatic send(input logic [7:0] b, input logic [3:0] elo, input logic [3:0] ehi, input int mode);
    logic [3:0] lo = b[3:0];
    logic [3:0] hi = b[7:4];
    cur_req = "R2";
    tx_valid = 1'b1; tx_byte = b;
    e_out = {1'b1, lo}; e_rdy = 1'b0; step();
    tx_valid = 1'b0;
    e_out = {1'b0, lo}; step();
    if (mode == 1) begin
      cur_req = "R7";
      repeat (lim) step();
      e_out = {1'b1, lo}; e_to = 1'b1; e_rdy = 1'b1; step();
      e_to = 1'b0; step();
      return;
    end
    cur_req = "R3";
    link_in = {1'b0, elo}; step();
    link_in = {1'b1, elo}; step(); step();
    cur_req = "R4";
    e_out = {1'b0, hi}; e_err = (elo != lo); step();
    e_err = 1'b0;
    e_out = {1'b1, hi}; step();
    if (mode == 2) begin
      cur_req = "R11";
      repeat (lim) step();
      e_to = 1'b1; e_rdy = 1'b1; step();
      e_to = 1'b0; step(); step();
      link_in = {1'b0, elo}; repeat (4) step();
      return;
    end
    cur_req = "R5";
    link_in = {1'b1, ehi}; step();
    link_in = {1'b0, ehi}; step(); step();
    cur_req = "R6";
    e_rdy = 1'b1; e_err = (ehi != hi); step();
    e_err = 1'b0; step();
  endtask

  // mode 0: full byte, 1: high nibble never arrives
  task automatic recv(input logic [3:0] lo, input logic [3:0] hi, input int mode);
    cur_req = "R8";
    link_in = {1'b0, lo}; step();
    link_in = {1'b1, lo}; step();
    e_rdy = 1'b0; step();
    e_out = {1'b1, lo}; step();
    e_out = {1'b0, lo}; step();
    if (mode == 1) begin
      cur_req = "R10";
      repeat (lim) step();
      e_out = {1'b1, lo}; e_rdy = 1'b1; step(); step();
      link_in = {1'b0, lo}; repeat (4) step();
      return;
    end
    cur_req = "R12";
    tx_valid = 1'b1; tx_byte = 8'hFF;
    link_in = {1'b1, hi}; step();
    tx_valid = 1'b0;
    link_in = {1'b0, hi}; step(); step();
    cur_req = "R9";
    e_out = {1'b0, hi}; step();
    e_out = {1'b1, hi}; e_rv = 1'b1; e_rb = {hi, lo}; e_rdy = 1'b1; step();
    e_rv = 1'b0; step(); step();
  endtask

  initial begin
    rst = 1'b1; link_in = '0; tx_valid = 1'b0; tx_byte = '0;
    set_lim(5);
    e_out = 5'h10; e_rdy = 1'b1; e_rv = 1'b0; e_rb = 8'h00; e_err = 1'b0; e_to = 1'b0;
    cur_req = "R1";
    @(posedge clk); #2;
    step(); step();
    rst = 1'b0;
    step(); step();

    send(8'h9A, 4'hA, 4'h9, 0);   // R5 low nibble first
    send(8'h5C, 4'h3, 4'h5, 0);   // R6 bad low echo
    send(8'h37, 4'h7, 4'hE, 0);   // R6 bad high echo
    recv(4'h1, 4'hF, 0);          // R8 R9 R12
    set_lim(3);
    send(8'hB4, 4'h0, 4'h0, 1);   // R7 low wait expires
    send(8'h6D, 4'hD, 4'h0, 2);   // R7 R11 high wait expires, busy stuck
    recv(4'h8, 4'h0, 1);          // R10
    set_lim(5);
    send(8'h00, 4'h0, 4'h0, 0);
    recv(4'h6, 4'hC, 0);
    send(8'hFF, 4'hF, 4'hF, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule